// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block sits between the clock-generation logic of a programmable oscillator and its two output pads. The reference output can carry either the master clock or a prescaled clock; the main output carries the divider chain. Two synchronized control pins are read in light of four configuration bits. From them the block derives the reference mux select, an enable request for each output, and a device power-down request. It then drives the pad tri-state enables so that an output is never cut or started in the middle of a high phase.

A power-down request must be held for a programmable number of periods of the slowest output, counted on a one-cycle `slow_tick` strobe, before it is acted on. Once qualified, both outputs are drained to Hi-Z first, and only then is `pwr_down` raised. After reset, and again after every release from power-down, both outputs stay off for a stabilization interval of master clock cycles.

The sequencer has four states. `S_STARTUP` counts out the interval, goes to `S_RUN` when it ends, and goes to `S_DOWN` if a qualified power-down arrives first. `S_RUN` goes to `S_DRAIN` on a qualified power-down. `S_DRAIN` goes to `S_DOWN` once both gates are idle, and back to `S_RUN` if the request drops. `S_DOWN` goes to `S_STARTUP` when the request drops. Each output gate has four states. `G_OFF` goes to `G_ON` when enable is allowed and the clock is low, and to `G_WAIT_ON` when enable is allowed and the clock is high. `G_WAIT_ON` goes to `G_ON` when the clock goes low, and to `G_OFF` if enable is withdrawn. `G_ON` goes to `G_OFF` when enable is withdrawn and the clock is low, and to `G_WAIT_OFF` when enable is withdrawn and the clock is high. `G_WAIT_OFF` goes to `G_OFF` when the clock goes low, and to `G_ON` if enable returns. The pad is driven in `G_ON` and `G_WAIT_OFF`.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: After reset, `ref_oe`, `main_oe`, `pwr_down` and `startup_done` are 0. `startup_done` rises after STARTUP_CYCLES clock cycles, and no output is enabled while `startup_done` is 0.
- R2: With `cfg_pdn0`=1, `ref_mux_sel` equals `cfg_sel0` (0 = master clock, 1 = prescaled), the reference output is requested on, and `ctl0`=1 is a power-down request.
- R3: With `cfg_en0`=1 and `cfg_pdn0`=0, `ctl0`=1 turns the reference output off (Hi-Z) and `ctl0`=0 turns it on, while `ref_mux_sel` equals `cfg_sel0` whatever the level of `ctl0`.
- R4: With `cfg_sel0`=1 and `cfg_en0`=`cfg_pdn0`=0, `ref_mux_sel` follows `ctl0` and the reference output is requested on.
- R5: With `cfg_en0`=`cfg_sel0`=`cfg_pdn0`=0, the reference output is never enabled and `ctl0`=1 is a power-down request.
- R6: With `cfg_pdn1`=0, `ctl1`=1 turns the main output off and `ctl1`=0 turns it on. With `cfg_pdn1`=1, the main output is requested on and `ctl1`=1 is a power-down request.
- R7: An output enable changes level only at a clock edge where that output's low flag (`ref_low` or `main_low`) is 1. A change of request made while the flag is 0 is held until the flag is 1.
- R8: A power-down request from either pin takes effect only after `slow_tick` has pulsed PD_PERIODS+1 times while the request is held continuously. If the request drops, the count restarts from zero.
- R9: `pwr_down` rises only after both output enables are 0, and both enables stay 0 while `pwr_down` is 1.
- R10: When a qualified power-down request is removed, `pwr_down` falls, `startup_done` is 0, and the stabilization interval of R1 runs again before any output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl0 | input | 1 | Synchronized control pin 0 |
| ctl1 | input | 1 | Synchronized control pin 1 |
| cfg_en0 | input | 1 | Pin 0 acts as reference output enable |
| cfg_sel0 | input | 1 | Reference frequency select / pin 0 mux-select mode |
| cfg_pdn0 | input | 1 | Pin 0 acts as power-down |
| cfg_pdn1 | input | 1 | Pin 1 acts as power-down (else main output enable) |
| ref_low | input | 1 | Reference output clock currently low |
| main_low | input | 1 | Main output clock currently low |
| slow_tick | input | 1 | One-cycle strobe per period of the slowest output |
| ref_oe | output | 1 | Reference pad drive enable (0 = Hi-Z) |
| main_oe | output | 1 | Main pad drive enable (0 = Hi-Z) |
| ref_mux_sel | output | 1 | Reference mux: 0 master clock, 1 prescaled clock |
| pwr_down | output | 1 | Device power-down request |
| startup_done | output | 1 | Stabilization interval complete, outputs may run |

## Verification
The hardest situation to reach from the ports is the drain window. Here a power-down is already qualified, but one output is still high, so `pwr_down` must hold off while that enable stays up. The bench gets there by holding `main_low` at 0 before it raises the power-down pin and pulses `slow_tick` enough times to qualify. It checks that `pwr_down` is still 0 and `main_oe` still 1, then lets the clock fall and expects the enable to drop before `pwr_down` rises. Qualification is also probed one tick short, and every power-down is released so that the restarted stabilization interval is observed.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

    typedef enum logic [1:0] {
        G_OFF      = 2'd0,
        G_WAIT_ON  = 2'd1,
        G_ON       = 2'd2,
        G_WAIT_OFF = 2'd3
    } gate_state_t;

    typedef enum logic [1:0] {
        S_STARTUP = 2'd0,
        S_RUN     = 2'd1,
        S_DRAIN   = 2'd2,
        S_DOWN    = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic ref_sel;
        logic ref_req;
        logic main_req;
        logic pd_req;
    } pin_decode_t;

endpackage

// File: rtl/clkout_pin_decode.sv
module clkout_pin_decode
    import clkout_gate_pkg::*;
(
    input  logic        ctl0,
    input  logic        ctl1,
    input  logic        cfg_en0,
    input  logic        cfg_sel0,
    input  logic        cfg_pdn0,
    input  logic        cfg_pdn1,
    output pin_decode_t dec
);

    logic pd0;
    logic pd1;

    // Pin 0: power-down has top priority, then output enable,
    // then mux select; all-zero leaves pin 0 as a shutdown only.
    always_comb begin
        dec.ref_sel = cfg_sel0;
        dec.ref_req = 1'b1;
        pd0         = 1'b0;
        if (cfg_pdn0) begin
            pd0 = ctl0;
        end else if (cfg_en0) begin
            dec.ref_req = ~ctl0;
        end else if (cfg_sel0) begin
            dec.ref_sel = ctl0;
        end else begin
            dec.ref_req = 1'b0;
            pd0         = ctl0;
        end
    end

    // Pin 1: power-down or main-output enable.
    always_comb begin
        if (cfg_pdn1) begin
            dec.main_req = 1'b1;
            pd1          = ctl1;
        end else begin
            dec.main_req = ~ctl1;
            pd1          = 1'b0;
        end
    end

    assign dec.pd_req = pd0 | pd1;

endmodule

// File: rtl/clkout_pd_filter.sv
module clkout_pd_filter #(
    parameter int PD_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic slow_tick,
    output logic pd_qual
);

    // One extra tick: the first one may close a partial period.
    localparam int NEED = PD_PERIODS + 1;
    localparam int CW   = $clog2(NEED + 1);

    logic [CW-1:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            pd_qual  <= 1'b0;
        end else if (!pd_req) begin
            tick_cnt <= '0;
            pd_qual  <= 1'b0;
        end else if (!pd_qual && slow_tick) begin
            tick_cnt <= tick_cnt + 1'b1;
            if (tick_cnt == CW'(NEED - 1)) begin
                pd_qual <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkout_gate_fsm.sv
module clkout_gate_fsm
    import clkout_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic clk_low,
    output logic oe,
    output logic idle
);

    gate_state_t state_q;
    gate_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= G_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_OFF: begin
                if (allow) begin
                    state_d = clk_low ? G_ON : G_WAIT_ON;
                end
            end
            G_WAIT_ON: begin
                if (!allow) begin
                    state_d = G_OFF;
                end else if (clk_low) begin
                    state_d = G_ON;
                end
            end
            G_ON: begin
                if (!allow) begin
                    state_d = clk_low ? G_OFF : G_WAIT_OFF;
                end
            end
            G_WAIT_OFF: begin
                if (allow) begin
                    state_d = G_ON;
                end else if (clk_low) begin
                    state_d = G_OFF;
                end
            end
            default: state_d = G_OFF;
        endcase
    end

    // Registered pad enable: no decode glitch reaches the pad.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe <= 1'b0;
        end else begin
            oe <= (state_d == G_ON) || (state_d == G_WAIT_OFF);
        end
    end

    assign idle = (state_q == G_OFF);

endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
    import clkout_gate_pkg::*;
#(
    parameter int STARTUP_CYCLES = 8000,
    parameter int PD_PERIODS     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl0,
    input  logic ctl1,
    input  logic cfg_en0,
    input  logic cfg_sel0,
    input  logic cfg_pdn0,
    input  logic cfg_pdn1,
    input  logic ref_low,
    input  logic main_low,
    input  logic slow_tick,
    output logic ref_oe,
    output logic main_oe,
    output logic ref_mux_sel,
    output logic pwr_down,
    output logic startup_done
);

    localparam int NOUT = 2;
    localparam int SCW  = $clog2(STARTUP_CYCLES + 1);

    pin_decode_t     dec;
    logic            pd_qual;
    seq_state_t      seq_q;
    seq_state_t      seq_d;
    logic [SCW-1:0]  stab_cnt;
    logic            stab_last;
    logic [NOUT-1:0] req;
    logic [NOUT-1:0] low;
    logic [NOUT-1:0] oe;
    logic [NOUT-1:0] idle;

    clkout_pin_decode u_decode (
        .ctl0     (ctl0),
        .ctl1     (ctl1),
        .cfg_en0  (cfg_en0),
        .cfg_sel0 (cfg_sel0),
        .cfg_pdn0 (cfg_pdn0),
        .cfg_pdn1 (cfg_pdn1),
        .dec      (dec)
    );

    clkout_pd_filter #(
        .PD_PERIODS (PD_PERIODS)
    ) u_pd_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (dec.pd_req),
        .slow_tick (slow_tick),
        .pd_qual   (pd_qual)
    );

    // Stabilization counter, active only in S_STARTUP.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stab_cnt <= '0;
        end else if (seq_q == S_STARTUP) begin
            if (!stab_last) begin
                stab_cnt <= stab_cnt + 1'b1;
            end
        end else begin
            stab_cnt <= '0;
        end
    end

    assign stab_last = (stab_cnt == SCW'(STARTUP_CYCLES - 1));

    // Sequencer state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= S_STARTUP;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            S_STARTUP: begin
                if (pd_qual) begin
                    seq_d = S_DOWN;
                end else if (stab_last) begin
                    seq_d = S_RUN;
                end
            end
            S_RUN: begin
                if (pd_qual) begin
                    seq_d = S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (!pd_qual) begin
                    seq_d = S_RUN;
                end else if (&idle) begin
                    seq_d = S_DOWN;
                end
            end
            S_DOWN: begin
                if (!pd_qual) begin
                    seq_d = S_STARTUP;
                end
            end
            default: seq_d = S_STARTUP;
        endcase
    end

    // Sequencer outputs, registered from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_down     <= 1'b0;
            startup_done <= 1'b0;
        end else begin
            pwr_down     <= (seq_d == S_DOWN);
            startup_done <= (seq_d == S_RUN) || (seq_d == S_DRAIN);
        end
    end

    assign req[0] = dec.ref_req;
    assign req[1] = dec.main_req;
    assign low[0] = ref_low;
    assign low[1] = main_low;

    for (genvar g = 0; g < NOUT; g++) begin : g_gate
        clkout_gate_fsm u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .allow   (req[g] && (seq_q == S_RUN)),
            .clk_low (low[g]),
            .oe      (oe[g]),
            .idle    (idle[g])
        );
    end

    assign ref_oe      = oe[0];
    assign main_oe     = oe[1];
    assign ref_mux_sel = dec.ref_sel;

endmodule

// File: rtl/clkout_gate_ctrl_chk.sv
module clkout_gate_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_low,
    input logic main_low,
    input logic ref_oe,
    input logic main_oe,
    input logic pwr_down,
    input logic startup_done
);

    assert_no_oe_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !startup_done |-> (!ref_oe && !main_oe));

    assert_ref_rise_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_oe) |-> $past(ref_low));

    assert_ref_fall_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_oe) |-> $past(ref_low));

    assert_main_rise_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_oe) |-> $past(main_low));

    assert_main_fall_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_oe) |-> $past(main_low));

    assert_drain_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $past(!ref_oe && !main_oe));

    assert_off_while_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!ref_oe && !main_oe));

    assert_down_not_started_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !startup_done);

endmodule

bind clkout_gate_ctrl clkout_gate_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_low      (ref_low),
    .main_low     (main_low),
    .ref_oe       (ref_oe),
    .main_oe      (main_oe),
    .pwr_down     (pwr_down),
    .startup_done (startup_done)
);

// File: tb/clkout_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_tb_top;

    localparam int STARTUP = 40;
    localparam int PDP     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl0 = 0, ctl1 = 0;
    logic cfg_en0 = 1, cfg_sel0 = 1, cfg_pdn0 = 0, cfg_pdn1 = 0;
    logic ref_low = 1, main_low = 1, slow_tick = 0;
    logic ref_oe, main_oe, ref_mux_sel, pwr_down, startup_done;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    clkout_gate_ctrl #(
        .STARTUP_CYCLES (STARTUP),
        .PD_PERIODS     (PDP)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl0         (ctl0),
        .ctl1         (ctl1),
        .cfg_en0      (cfg_en0),
        .cfg_sel0     (cfg_sel0),
        .cfg_pdn0     (cfg_pdn0),
        .cfg_pdn1     (cfg_pdn1),
        .ref_low      (ref_low),
        .main_low     (main_low),
        .slow_tick    (slow_tick),
        .ref_oe       (ref_oe),
        .main_oe      (main_oe),
        .ref_mux_sel  (ref_mux_sel),
        .pwr_down     (pwr_down),
        .startup_done (startup_done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1;
            cyc(1);
            slow_tick = 1'b0;
            cyc(2);
        end
    endtask

    task automatic set_cfg(input logic en0, input logic sel0, input logic pdn0, input logic pdn1);
        cfg_en0 = en0; cfg_sel0 = sel0; cfg_pdn0 = pdn0; cfg_pdn1 = pdn1;
    endtask

    // R10: drop power-down, expect restart of stabilization.
    task automatic release_and_restart(input string req);
        ctl0 = 1'b0; ctl1 = 1'b0;
        cyc(3);
        chk(req, "pwr_down after release", pwr_down, 1'b0);
        chk("R10", "startup_done low on restart", startup_done, 1'b0);
        cyc(STARTUP + 4);
        chk("R10", "startup_done after restart", startup_done, 1'b1);
    endtask

    task automatic t_reset_startup();
        chk("R1", "ref_oe in reset", ref_oe, 1'b0);
        chk("R1", "main_oe in reset", main_oe, 1'b0);
        chk("R1", "pwr_down in reset", pwr_down, 1'b0);
        chk("R1", "startup_done in reset", startup_done, 1'b0);
        rst_n = 1'b1;
        cyc(STARTUP - 4);
        chk("R1", "startup_done early", startup_done, 1'b0);
        chk("R1", "ref_oe early", ref_oe, 1'b0);
        cyc(8);
        chk("R1", "startup_done late", startup_done, 1'b1);
        chk("R1", "ref_oe running", ref_oe, 1'b1);
        chk("R1", "main_oe running", main_oe, 1'b1);
    endtask

    task automatic t_en0_mode();
        set_cfg(1, 0, 0, 0);
        ctl0 = 0; cyc(3);
        chk("R3", "mux fixed by sel0=0, pin low", ref_mux_sel, 1'b0);
        ref_low = 0; ctl0 = 1; cyc(4);
        chk("R3", "mux fixed by sel0=0, pin high", ref_mux_sel, 1'b0);
        chk("R7", "ref_oe held until low", ref_oe, 1'b1);
        ref_low = 1; cyc(3);
        chk("R3", "ref_oe off with pin high", ref_oe, 1'b0);
        cfg_sel0 = 1; cyc(1);
        chk("R3", "mux follows sel0=1", ref_mux_sel, 1'b1);
        ctl0 = 0; cyc(3);
        chk("R3", "ref_oe on with pin low", ref_oe, 1'b1);
    endtask

    task automatic t_mux_mode();
        set_cfg(0, 1, 0, 0);
        ctl0 = 0; cyc(2);
        chk("R4", "mux select pin low", ref_mux_sel, 1'b0);
        ctl0 = 1; cyc(4);
        chk("R4", "mux select pin high", ref_mux_sel, 1'b1);
        chk("R4", "ref on in mux mode", ref_oe, 1'b1);
        chk("R4", "no power-down from mux pin", pwr_down, 1'b0);
        ctl0 = 0; cyc(1);
    endtask

    task automatic t_enable_wait();
        set_cfg(1, 1, 0, 0);
        ctl0 = 1; cyc(3);
        chk("R7", "ref off before test", ref_oe, 1'b0);
        ref_low = 0; ctl0 = 0; cyc(4);
        chk("R7", "enable waits for low", ref_oe, 1'b0);
        ref_low = 1; cyc(3);
        chk("R7", "enable after low", ref_oe, 1'b1);
    endtask

    task automatic t_main_pin();
        set_cfg(1, 1, 0, 0);
        ctl1 = 1; cyc(3);
        chk("R6", "main off with pin1 high", main_oe, 1'b0);
        ctl1 = 0; cyc(3);
        chk("R6", "main on with pin1 low", main_oe, 1'b1);
        cfg_pdn1 = 1; ctl1 = 1; cyc(3);
        chk("R6", "main on while pin1 is power-down", main_oe, 1'b1);
        ticks(PDP + 1); cyc(4);
        chk("R6", "pin1 power-down", pwr_down, 1'b1);
        release_and_restart("R6");
    endtask

    task automatic t_pdn0_mode();
        set_cfg(0, 0, 1, 0);
        ctl0 = 0; cyc(3);
        chk("R2", "sel0=0 gives master", ref_mux_sel, 1'b0);
        chk("R2", "ref on", ref_oe, 1'b1);
        cfg_sel0 = 1; ctl0 = 1; cyc(1);
        chk("R2", "sel0=1 gives prescaled", ref_mux_sel, 1'b1);
        ticks(PDP + 1); cyc(4);
        chk("R2", "pin0 power-down", pwr_down, 1'b1);
        release_and_restart("R2");
    endtask

    task automatic t_all_zero();
        set_cfg(0, 0, 0, 0);
        ctl0 = 0; cyc(4);
        chk("R5", "ref disabled", ref_oe, 1'b0);
        chk("R5", "no power-down with pin low", pwr_down, 1'b0);
        ctl0 = 1; ticks(PDP + 1); cyc(4);
        chk("R5", "pin0 power-down", pwr_down, 1'b1);
        release_and_restart("R5");
        chk("R5", "ref stays disabled after restart", ref_oe, 1'b0);
    endtask

    task automatic t_qualify();
        set_cfg(1, 1, 0, 1);
        cyc(3);
        ctl1 = 1; ticks(PDP); cyc(4);
        chk("R8", "not qualified one tick short", pwr_down, 1'b0);
        ctl1 = 0; cyc(2); ctl1 = 1;
        ticks(1); cyc(4);
        chk("R8", "count restarted after drop", pwr_down, 1'b0);
        ticks(PDP); cyc(4);
        chk("R8", "qualified after full count", pwr_down, 1'b1);
        release_and_restart("R8");
    endtask

    task automatic t_drain();
        set_cfg(1, 1, 0, 1);
        cyc(3);
        chk("R9", "main on before drain", main_oe, 1'b1);
        main_low = 0; ctl1 = 1;
        ticks(PDP + 1); cyc(4);
        chk("R9", "pwr_down waits for drain", pwr_down, 1'b0);
        chk("R9", "main held while high", main_oe, 1'b1);
        chk("R9", "ref drained", ref_oe, 1'b0);
        main_low = 1; cyc(1);
        chk("R9", "main drops first", main_oe, 1'b0);
        cyc(3);
        chk("R9", "pwr_down after drain", pwr_down, 1'b1);
        chk("R9", "main off while down", main_oe, 1'b0);
        release_and_restart("R9");
    endtask

    initial begin : watchdog
        cyc(20000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main_seq
        cyc(3);
        t_reset_startup();
        t_en0_mode();
        t_mux_mode();
        t_enable_wait();
        t_main_pin();
        t_pdn0_mode();
        t_all_zero();
        t_qualify();
        t_drain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule